// File: doc/BRIEF.md
# Region Master-Clock Phase Generator

This block derives the processor-cycle and video-dot timing of a retro console core from one fast master clock. For each of three television regions it divides the master clock by a region-specific processor divider and a separate dot divider. It marks the two halves of every processor cycle with one-tick strobes: one at the cycle's first tick and one where the second half begins.

The boundary between the two halves is not fixed. For a read cycle the first half is one master tick shorter than its nominal count and the second half one tick longer; for a write cycle it is the other way round. The total cycle length stays equal to the divider. The read/write kind of each cycle is taken from an input at the tick that opens the cycle. The dot enable runs freely at its own divider. Both streams start after phase offsets that are applied once, when reset is released, so that a system model can reproduce any alignment between processor and video.

Top module: `mclk_phase_gen`

## Requirements
- R1: While `rst` is high all three strobes are low. Region select and both offsets are captured only while `rst` is high; changing them after release has no effect on any output.
- R2: Region select encoding: 0 gives processor divider 12, nominal first half 6, dot divider 4; 1 gives 16, 8, 5; 2 gives 15, 7, 5; 3 behaves exactly like 0.
- R3: Counting the first rising edge with `rst` low as tick 0, `cyc_start_o` is high for exactly one clock after tick P, where P is the captured processor offset, and again every processor-divider ticks after that.
- R4: When `rd_i` is 1 at the tick that opens a cycle, `cyc_end_o` pulses for one clock at nominal-first-half minus 1 ticks after that opening tick.
- R5: When `rd_i` is 0 at the tick that opens a cycle, `cyc_end_o` pulses for one clock at nominal-first-half plus 1 ticks after that opening tick.
- R6: `rd_i` is sampled only at the tick that opens a cycle; changing it at any other tick does not move that cycle's `cyc_end_o`.
- R7: Counting the same tick 0, `dot_en_o` is high for one clock after tick D, where D is the captured dot offset, and again every dot-divider ticks after that.
- R8: A processor offset not smaller than the processor divider is treated as divider minus 1; a dot offset not smaller than the dot divider is treated as dot divider minus 1.
- R9: Between two consecutive `cyc_start_o` pulses there is exactly one `cyc_end_o` pulse, and the two strobes are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset; also the capture window for region and offsets |
| region_sel_i | input | 2 | Region select (encoding in R2) |
| rd_i | input | 1 | 1 = the cycle about to open is a read, 0 = a write |
| cpu_off_i | input | CPU_OFF_W (5) | Processor phase offset in master ticks |
| dot_off_i | input | DOT_OFF_W (3) | Dot phase offset in master ticks |
| cyc_start_o | output | 1 | One-clock strobe on the first tick of a processor cycle |
| cyc_end_o | output | 1 | One-clock strobe on the first tick of the second half |
| dot_en_o | output | 1 | One-clock video dot enable |

## Verification
Every strobe is a register set by the edge that decides it, so a strobe belonging to tick n is visible in the clock period right after rising edge n and nowhere else. The bench model numbers rising edges from reset release, predicts for each edge whether a start, end or dot strobe is due using the region constants, the clamped offsets and the `rd_i` value present at that edge, and compares all three outputs at the following falling edge. Read/write patterns, late changes of region and offsets, and out-of-range offsets are applied at falling edges so that the value seen by the next rising edge is unambiguous.

// File: rtl/mclk_phase_pkg.sv
package mclk_phase_pkg;

  localparam int CNT_W = 5;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  // per-region constants: processor divider, nominal first half, dot divider
  localparam logic [CNT_W-1:0] R0_CPU_DIV = CNT_W'(12);
  localparam logic [CNT_W-1:0] R0_HALF    = CNT_W'(6);
  localparam logic [CNT_W-1:0] R0_DOT_DIV = CNT_W'(4);
  localparam logic [CNT_W-1:0] R1_CPU_DIV = CNT_W'(16);
  localparam logic [CNT_W-1:0] R1_HALF    = CNT_W'(8);
  localparam logic [CNT_W-1:0] R1_DOT_DIV = CNT_W'(5);
  localparam logic [CNT_W-1:0] R2_CPU_DIV = CNT_W'(15);
  localparam logic [CNT_W-1:0] R2_HALF    = CNT_W'(7);
  localparam logic [CNT_W-1:0] R2_DOT_DIV = CNT_W'(5);

  typedef struct packed {
    logic [CNT_W-1:0] cpu_div;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] dot_div;
  } region_cfg_t;

  typedef enum logic [1:0] {PH_WAIT, PH_FIRST, PH_SECOND} cyc_phase_t;

  function automatic region_cfg_t region_cfg(input logic [1:0] sel);
    region_cfg_t c;
    case (sel)
      2'd1:    c = '{cpu_div: R1_CPU_DIV, half: R1_HALF, dot_div: R1_DOT_DIV};
      2'd2:    c = '{cpu_div: R2_CPU_DIV, half: R2_HALF, dot_div: R2_DOT_DIV};
      default: c = '{cpu_div: R0_CPU_DIV, half: R0_HALF, dot_div: R0_DOT_DIV};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mclk_off_clamp.sv
module mclk_off_clamp
  import mclk_phase_pkg::*;
#(
  parameter int OFF_W = 5
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [CNT_W-1:0] div_i,
  output logic [CNT_W-1:0] off_o
);
  localparam int XW = OFF_W + CNT_W;

  logic [XW-1:0] off_x;
  logic [XW-1:0] div_x;

  assign off_x = XW'(off_i);
  assign div_x = XW'(div_i);
  assign off_o = (off_x >= div_x) ? (div_i - ONE) : off_x[CNT_W-1:0];
endmodule

// File: rtl/mclk_cpu_seq.sv
module mclk_cpu_seq
  import mclk_phase_pkg::*;
#(
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cpu_div_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             rd_i,
  output logic             start_o,
  output logic             end_o
);
  cyc_phase_t       ph;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] off_c;
  logic             rd_q;
  logic [CNT_W-1:0] second_m1;

  mclk_off_clamp #(.OFF_W(OFF_W)) i_clamp (
    .off_i(off_i), .div_i(cpu_div_i), .off_o(off_c)
  );

  // second half minus one: read lengthens it by a tick, write shortens it
  assign second_m1 = rd_q ? (cpu_div_i - half_i) : (cpu_div_i - half_i - TWO);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_WAIT;
      cnt     <= off_c;
      rd_q    <= 1'b1;
      start_o <= 1'b0;
      end_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      end_o   <= 1'b0;
      if (cnt != '0) begin
        cnt <= cnt - ONE;
      end else if (ph == PH_FIRST) begin
        end_o <= 1'b1;
        ph    <= PH_SECOND;
        cnt   <= second_m1;
      end else begin
        start_o <= 1'b1;
        ph      <= PH_FIRST;
        rd_q    <= rd_i;
        cnt     <= rd_i ? (half_i - TWO) : half_i;
      end
    end
  end
endmodule

// File: rtl/mclk_dot_div.sv
module mclk_dot_div
  import mclk_phase_pkg::*;
#(
  parameter int OFF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] dot_div_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             dot_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] off_c;

  mclk_off_clamp #(.OFF_W(OFF_W)) i_clamp (
    .off_i(off_i), .div_i(dot_div_i), .off_o(off_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= off_c;
      dot_o <= 1'b0;
    end else if (cnt == '0) begin
      cnt   <= dot_div_i - ONE;
      dot_o <= 1'b1;
    end else begin
      cnt   <= cnt - ONE;
      dot_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mclk_phase_gen.sv
module mclk_phase_gen
  import mclk_phase_pkg::*;
#(
  parameter int CPU_OFF_W = 5,
  parameter int DOT_OFF_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           region_sel_i,
  input  logic                 rd_i,
  input  logic [CPU_OFF_W-1:0] cpu_off_i,
  input  logic [DOT_OFF_W-1:0] dot_off_i,
  output logic                 cyc_start_o,
  output logic                 cyc_end_o,
  output logic                 dot_en_o
);
  logic [1:0]  region_q;
  region_cfg_t cfg;

  always_ff @(posedge clk) begin
    if (rst) region_q <= region_sel_i;
  end

  // during reset the offsets are clamped against the region being captured
  assign cfg = region_cfg(rst ? region_sel_i : region_q);

  mclk_cpu_seq #(.OFF_W(CPU_OFF_W)) i_cpu (
    .clk(clk), .rst(rst), .cpu_div_i(cfg.cpu_div), .half_i(cfg.half),
    .off_i(cpu_off_i), .rd_i(rd_i), .start_o(cyc_start_o), .end_o(cyc_end_o)
  );

  mclk_dot_div #(.OFF_W(DOT_OFF_W)) i_dot (
    .clk(clk), .rst(rst), .dot_div_i(cfg.dot_div), .off_i(dot_off_i), .dot_o(dot_en_o)
  );
endmodule

// File: rtl/mclk_phase_chk.sv
module mclk_phase_chk
  import mclk_phase_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] region_q,
  input logic       rd_i,
  input logic       cyc_start_o,
  input logic       cyc_end_o,
  input logic       dot_en_o
);
  region_cfg_t      c;
  logic             rd_d;
  logic             rw_ck;
  logic             seen_start;
  logic             seen_dot;
  logic             end_seen;
  logic [CNT_W:0]   since;
  logic [CNT_W:0]   dgap;

  assign c = region_cfg(region_q);

  always_ff @(posedge clk) begin
    rd_d <= rd_i;
    if (rst) begin
      rw_ck <= 1'b1; seen_start <= 1'b0; seen_dot <= 1'b0; end_seen <= 1'b0;
      since <= '0; dgap <= '0;
    end else begin
      if (cyc_start_o) begin
        since <= (CNT_W+1)'(1); seen_start <= 1'b1; rw_ck <= rd_d; end_seen <= 1'b0;
      end else begin
        if (since != '1) since <= since + (CNT_W+1)'(1);
        if (cyc_end_o) end_seen <= 1'b1;
      end
      if (dot_en_o) begin
        dgap <= (CNT_W+1)'(1); seen_dot <= 1'b1;
      end else if (dgap != '1) begin
        dgap <= dgap + (CNT_W+1)'(1);
      end
    end
  end

  // R1: outputs quiet in the clock after a reset edge
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |=> (!cyc_start_o && !cyc_end_o && !dot_en_o));

  // R3
  a_r3_start_period: assert property (@(posedge clk) disable iff (rst)
    (cyc_start_o && seen_start) |-> (since == {1'b0, c.cpu_div}));

  // R4 and R5: second half begins at the read/write dependent tick
  a_r5_end_place: assert property (@(posedge clk) disable iff (rst)
    cyc_end_o |-> (seen_start && since == (rw_ck ? {1'b0, c.half - ONE} : {1'b0, c.half + ONE})));

  // R7
  a_r7_dot_period: assert property (@(posedge clk) disable iff (rst)
    (dot_en_o && seen_dot) |-> (dgap == {1'b0, c.dot_div}));

  // R9
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(cyc_start_o && cyc_end_o));

  a_r9_one_end_per_cycle: assert property (@(posedge clk) disable iff (rst)
    (cyc_start_o && seen_start) |-> end_seen);
endmodule

bind mclk_phase_gen mclk_phase_chk i_chk (
  .clk(clk), .rst(rst), .region_q(region_q), .rd_i(rd_i),
  .cyc_start_o(cyc_start_o), .cyc_end_o(cyc_end_o), .dot_en_o(dot_en_o)
);

// File: tb/test_mclk_phase_gen.sv
`timescale 1ns/1ps
module test_mclk_phase_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] region_sel = 2'd0;
  logic       rd = 1'b1;
  logic [4:0] cpu_off = 5'd0;
  logic [2:0] dot_off = 3'd1;
  logic       cyc_start, cyc_end, dot_en;

  int tests = 0;
  int fails = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  mclk_phase_gen i_mclk_phase_gen (
    .clk(clk), .rst(rst), .region_sel_i(region_sel), .rd_i(rd),
    .cpu_off_i(cpu_off), .dot_off_i(dot_off),
    .cyc_start_o(cyc_start), .cyc_end_o(cyc_end), .dot_en_o(dot_en)
  );

  // behavioural reference: absolute tick numbers of the next due events
  int  n, nstart, nend, ndot, mcpu, mhalf, mdot;
  bit  e_start, e_end, e_dot, e_rd, have_model, in_rst;

  always @(posedge clk) begin
    if (rst) begin
      case (region_sel)
        2'd1:    begin mcpu = 16; mhalf = 8; mdot = 5; end
        2'd2:    begin mcpu = 15; mhalf = 7; mdot = 5; end
        default: begin mcpu = 12; mhalf = 6; mdot = 4; end
      endcase
      nstart = (int'(cpu_off) >= mcpu) ? mcpu - 1 : int'(cpu_off);
      ndot   = (int'(dot_off) >= mdot) ? mdot - 1 : int'(dot_off);
      nend = -1; n = 0;
      e_start = 0; e_end = 0; e_dot = 0; in_rst = 1;
    end else begin
      in_rst  = 0;
      e_start = (n == nstart);
      e_end   = (n == nend);
      e_dot   = (n == ndot);
      if (e_start) begin
        e_rd   = rd;
        nend   = n + (rd ? mhalf - 1 : mhalf + 1);
        nstart = n + mcpu;
      end
      if (e_dot) ndot = n + mdot;
      n++;
    end
    have_model = 1;
  end

  task automatic check(input string req, input logic act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] tick %0d: actual %b expected %b", req, cur_tag, n, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (have_model) begin
      if (in_rst) begin
        check("R1", cyc_start, 1'b0);
        check("R1", cyc_end, 1'b0);
        check("R1", dot_en, 1'b0);
      end else begin
        check("R3", cyc_start, e_start);
        check(e_rd ? "R4" : "R5", cyc_end, e_end);
        check("R7", dot_en, e_dot);
      end
    end
  end

  // mode 0 all reads, 1 all writes, 2 mixed and changing inside cycles (R6)
  task automatic run_case(input string tag, input logic [1:0] rs, input int coff,
                          input int doff, input int mode, input bit disturb);
    @(negedge clk);
    rst = 1'b1; region_sel = rs; cpu_off = 5'(coff); dot_off = 3'(doff); cur_tag = tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 240; i++) begin
      rd = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : (((i * 5 + i / 3) % 3) == 0);
      if (disturb && i == 30) begin
        region_sel = ~rs; cpu_off = 5'd29; dot_off = 3'd6;  // R1: ignored after release
      end
      @(negedge clk);
    end
  endtask

  initial begin
    run_case("R2 region0 reads R4",  2'd0, 0, 1, 0, 0);
    run_case("R2 region1 writes R5", 2'd1, 3, 2, 1, 0);
    run_case("R2 region2 mixed R6",  2'd2, 14, 4, 2, 0);
    run_case("R2 region3 as 0",      2'd3, 5, 0, 2, 0);
    run_case("R8 clamp region0",     2'd0, 31, 7, 2, 0);
    run_case("R8 clamp region1",     2'd1, 20, 6, 1, 0);
    run_case("R1 late changes",      2'd2, 6, 3, 2, 1);
    run_case("R6 region1 mixed",     2'd1, 9, 1, 2, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule